// File: doc/BRIEF.md
# Scanned Key Matrix Controller

This block walks a 5-column by 4-row switch matrix and queues the positions of pressed keys for a host processor. A free-running 4-bit scan count appears on the scan outputs and advances once every `SCAN_DIV` clocks. Counts whose low three bits are 0 to 4 drive one of five active-high column lines. Counts whose low three bits are 5 to 7 leave every column idle. The four return lines pass through a two-flop synchronizer. During the last four clocks of each column's dwell, one return line is evaluated per clock.

A key is accepted once it has read closed on two consecutive visits of its column. A visit comes once per eight counts. An accepted key is stored once per press as a 5-bit code in an 8-entry FIFO.

The host reaches the block through an 8-bit port with an active-low select, a register-select line, and active-low write and read strobes. The host strobes are treated as synchronous to `clk`. With the register-select line low the port carries key data, and reading it removes the oldest key. With it high, reads return status and writes are commands. Command 0xC0 empties the queue.

Top module: `keymatrix_scanner`

## Requirements
- R1: With `cs_n` high, strobes on `rd_n` and `wr_n` have no effect. `dout_en` is high exactly while `cs_n` and `rd_n` are both low.
- R2: After reset, `scan` starts at 0 and increments by one every `SCAN_DIV` clocks, wrapping from 15 to 0.
- R3: When `scan[2:0]` is 0 to 4, `col` is one-hot with bit `scan[2:0]` set. When `scan[2:0]` is 5, 6 or 7, `col` is all zero.
- R4: A key at column c, row r is stored as code `{c[2:0], r[1:0]}`. A data read returns this code in bits [4:0], with bits [7:5] zero.
- R5: A key that reads closed on only one visit of its column is never stored.
- R6: A held key is stored once only. After it has read open on one visit, a new press is stored again.
- R7: The queue holds 8 codes in arrival order. A code accepted while the queue is full is dropped and sets a sticky overflow flag.
- R8: A data read (`a0`=0) removes the oldest code when `rd_n` rises. A data read on an empty queue returns 0x00 and changes nothing.
- R9: A status read (`a0`=1) returns bit 7 = empty, bit 6 = overflow, bits [3:0] = entry count, and zero in bits 5 and 4.
- R10: A write takes effect when `wr_n` rises. With `a0`=1 and value 0xC0, it clears the queue and the overflow flag. Any other write changes nothing.
- R11: Keys pressed together in one column are all stored, in ascending row order.
- R12: After reset, the queue is empty, overflow is clear, `scan` is 0 and `col` is 5'b00001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Port select, active low |
| a0 | input | 1 | 0 selects key data, 1 selects status or command |
| wr_n | input | 1 | Write strobe, active low; acts on the rising edge |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host, zero when not driven |
| dout_en | output | 1 | High while the block drives read data |
| scan | output | 4 | Binary scan count |
| col | output | 5 | Column drives, active high |
| ret | input | 4 | Return lines from the matrix, high when a switch is closed |

## Verification
The bench uses the default parameters: `SCAN_DIV` = 8 and `FIFO_DEPTH` = 8. The short dwell puts two column visits 64 clocks apart. This makes the two-visit acceptance, the single-visit rejection and the re-press after release cheap to reach. Nine sequential presses then fill the queue past its depth within a few thousand cycles, which exposes the overflow, ordering and clear-command paths. The bench models the switch matrix from `col`, so row timing depends on the real column walk rather than on injected return values.

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner #(
  parameter int SCAN_DIV   = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       a0,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic [3:0] scan,
  output logic [4:0] col,
  input  logic [3:0] ret
);

  localparam int DW    = $clog2(SCAN_DIV);
  localparam int PW    = $clog2(FIFO_DEPTH);
  localparam int CW    = PW + 1;
  localparam int NCOL  = 5;
  localparam int NKEY  = NCOL * 4;
  localparam int EVAL0 = SCAN_DIV - 4;

  // scan timing
  logic [DW-1:0] div;
  logic [3:0]    scan_q;
  wire           tick = (div == DW'(SCAN_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div    <= '0;
      scan_q <= '0;
    end else if (tick) begin
      div    <= '0;
      scan_q <= scan_q + 4'd1;
    end else begin
      div <= div + DW'(1);
    end

  assign scan = scan_q;

  always_comb begin
    col = '0;
    if (scan_q[2:0] < 3'(NCOL)) col[scan_q[2:0]] = 1'b1;
  end

  // return line synchronizer
  logic [3:0] ret_m, ret_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ret_m <= '0;
      ret_s <= '0;
    end else begin
      ret_m <= ret;
      ret_s <= ret_m;
    end

  // per-key debounce, one row per clock
  logic       eval, closed, hit;
  logic [1:0] row;
  logic [4:0] kidx, code;
  logic [NKEY-1:0] seen_q, done_q;

  assign eval   = (div >= DW'(EVAL0)) && (scan_q[2:0] < 3'(NCOL));
  assign row    = 2'(div - DW'(EVAL0));
  assign kidx   = {2'b00, scan_q[2:0]} * 5'd4 + {3'b000, row};
  assign code   = {scan_q[2:0], row};
  assign closed = ret_s[row];
  assign hit    = eval && closed && seen_q[kidx] && !done_q[kidx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen_q <= '0;
      done_q <= '0;
    end else if (eval) begin
      seen_q[kidx] <= closed;
      if (!closed)  done_q[kidx] <= 1'b0;
      else if (hit) done_q[kidx] <= 1'b1;
    end

  // host port
  logic       wr_q, rd_q, wr_cs, wr_a0, rd_cs, rd_a0;
  logic [7:0] wr_dat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q   <= 1'b1;
      rd_q   <= 1'b1;
      wr_cs  <= 1'b0;
      wr_a0  <= 1'b0;
      wr_dat <= '0;
      rd_cs  <= 1'b0;
      rd_a0  <= 1'b0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
      if (!wr_n) begin
        wr_cs  <= !cs_n;
        wr_a0  <= a0;
        wr_dat <= din;
      end
      if (!rd_n) begin
        rd_cs <= !cs_n;
        rd_a0 <= a0;
      end
    end

  // key queue
  logic [4:0]    mem [FIFO_DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          ovf_q;

  wire empty  = (cnt == '0);
  wire full   = (cnt == CW'(FIFO_DEPTH));
  wire clr    = wr_n && !wr_q && wr_cs && wr_a0 && (wr_dat == 8'hC0);
  wire do_pop = rd_n && !rd_q && rd_cs && !rd_a0 && !empty && !clr;
  wire do_put = hit && !full && !clr;

  always_ff @(posedge clk)
    if (do_put) mem[wp] <= code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      rp    <= '0;
      wp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_put) wp <= (wp == PW'(FIFO_DEPTH - 1)) ? '0 : wp + PW'(1);
      if (do_pop) rp <= (rp == PW'(FIFO_DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(do_put) - CW'(do_pop);
      if (hit && full) ovf_q <= 1'b1;
    end

  // read mux
  wire [7:0] status = {empty, ovf_q, 2'b00, 4'(cnt)};
  wire [7:0] keyout = empty ? 8'h00 : {3'b000, mem[rp]};

  assign dout_en = !cs_n && !rd_n;
  assign dout    = !dout_en ? 8'h00 : (a0 ? status : keyout);

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_q != $past(scan_q)) |-> (scan_q == $past(scan_q) + 4'd1));

  // R3
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_DEPTH));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_q) && !$past(clr)) |-> ovf_q);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1) || cnt + CW'(1) == $past(cnt)));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !ovf_q));

endmodule

// File: tb/test_keymatrix_scanner.sv
`timescale 1ns/1ps
module test_keymatrix_scanner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, a0 = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic [3:0] scan;
  logic [4:0] col;
  logic [3:0] ret;
  logic [19:0] keys = '0;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keymatrix_scanner #(.SCAN_DIV(8), .FIFO_DEPTH(8)) i_keymatrix_scanner (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a0(a0), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .dout_en(dout_en), .scan(scan), .col(col), .ret(ret)
  );

  // switch matrix model
  always_comb begin
    ret = '0;
    for (int c = 0; c < 5; c++)
      for (int r = 0; r < 4; r++)
        if (col[c] && keys[c*4+r]) ret[r] = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic csv, input logic a0v, output logic [7:0] v, output logic en);
    @(negedge clk); cs_n = csv; a0 = a0v; rd_n = 1'b0;
    @(negedge clk); v = dout; en = dout_en; rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic csv, input logic a0v, input logic [7:0] d);
    @(negedge clk); cs_n = csv; a0 = a0v; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic press(input int idx, input int hold);
    keys[idx] = 1'b1;
    repeat (hold) @(negedge clk);
    keys[idx] = 1'b0;
    repeat (150) @(negedge clk);
  endtask

  // {column, row, expected code}
  localparam logic [12:0] VEC [6] = '{
    {3'd0, 2'd0, 8'h00}, {3'd4, 2'd3, 8'h13}, {3'd2, 2'd1, 8'h09},
    {3'd1, 2'd2, 8'h06}, {3'd3, 2'd0, 8'h0C}, {3'd0, 2'd3, 8'h03}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state, R2/R3 scan walk
    chk("R12 scan", scan, 0);
    chk("R12 col", col, 5'b00001);
    for (int n = 0; n < 18; n++) begin
      chk("R2 scan count", scan, n % 16);
      chk("R3 column decode", col, ((n % 8) < 5) ? (1 << (n % 8)) : 0);
      repeat (8) @(negedge clk);
    end
    chk("R1 idle dout_en", dout_en, 0);
    bus_read(1'b0, 1'b1, v, en);
    chk("R12 status", v, 8'h80);
    chk("R1 dout_en selected", en, 1);

    // R4 table of single keys
    for (int i = 0; i < 6; i++) begin
      press(VEC[i][12:10] * 4 + VEC[i][9:8], 300);
      bus_read(1'b0, 1'b1, v, en);
      chk("R6 one entry", v, 8'h01);
      bus_read(1'b0, 1'b0, v, en);
      chk("R4 key code", v, VEC[i][7:0]);
      bus_read(1'b0, 1'b1, v, en);
      chk("R8 popped", v, 8'h80);
    end

    // R5 short closure rejected
    keys[5] = 1'b1;
    repeat (40) @(negedge clk);
    keys[5] = 1'b0;
    repeat (200) @(negedge clk);
    bus_read(1'b0, 1'b1, v, en);
    chk("R5 glitch ignored", v, 8'h80);

    // R6 long hold stored once, re-press stored again
    press(6, 600);
    bus_read(1'b0, 1'b1, v, en);
    chk("R6 long hold once", v, 8'h01);
    bus_read(1'b0, 1'b0, v, en);
    press(6, 300);
    bus_read(1'b0, 1'b1, v, en);
    chk("R6 re-press", v, 8'h01);
    bus_read(1'b0, 1'b0, v, en);
    chk("R6 re-press code", v, 8'h06);

    // R11 two keys in one column
    keys[11] = 1'b1; keys[8] = 1'b1;
    repeat (300) @(negedge clk);
    keys = '0;
    repeat (150) @(negedge clk);
    bus_read(1'b0, 1'b1, v, en);
    chk("R11 two stored", v, 8'h02);
    bus_read(1'b0, 1'b0, v, en);
    chk("R11 lower row first", v, 8'h08);
    bus_read(1'b0, 1'b0, v, en);
    chk("R11 higher row second", v, 8'h0B);

    // R7 overflow: nine keys, codes equal key index
    for (int k = 0; k < 9; k++) press(k, 200);
    bus_read(1'b0, 1'b1, v, en);
    chk("R7 full with overflow", v, 8'h48);
    bus_read(1'b0, 1'b0, v, en);
    chk("R7 order first", v, 8'h00);
    bus_read(1'b0, 1'b0, v, en);
    chk("R7 order second", v, 8'h01);
    bus_read(1'b0, 1'b1, v, en);
    chk("R9 status after pops", v, 8'h46);

    // R1 deselected read and write
    bus_read(1'b1, 1'b0, v, en);
    chk("R1 deselected dout_en", en, 0);
    bus_write(1'b1, 1'b1, 8'hC0);
    bus_read(1'b0, 1'b1, v, en);
    chk("R1 deselected no effect", v, 8'h46);

    // R10 other writes ignored, clear command
    bus_write(1'b0, 1'b0, 8'hC0);
    bus_read(1'b0, 1'b1, v, en);
    chk("R10 data write ignored", v, 8'h46);
    bus_write(1'b0, 1'b1, 8'h55);
    bus_read(1'b0, 1'b1, v, en);
    chk("R10 other command ignored", v, 8'h46);
    bus_write(1'b0, 1'b1, 8'hC0);
    bus_read(1'b0, 1'b1, v, en);
    chk("R10 clear", v, 8'h80);

    // R8 read of empty queue
    bus_read(1'b0, 1'b0, v, en);
    chk("R8 empty read data", v, 8'h00);
    bus_read(1'b0, 1'b1, v, en);
    chk("R8 empty read no change", v, 8'h80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule